// File: doc/BRIEF.md
# Stalling Pin-Addressed I/O Port

This block serves the input and output instructions of a small pipelined processor. The pipeline presents a request with a direction bit, an 8-bit pin number and a 16-bit write word. The pin number is the value held in the instruction's second register operand. The block decodes the pin and reaches one of four devices: a write-only LED register, a synchronized push button, the receive register of a serial port and the transmit register of that port.

Accesses to the LED, to the button and to unmapped pins complete in the cycle they are presented. A serial-port access blocks the processor rather than making software poll a status flag. While a byte is outstanding, the block raises a stall signal. The requester must hold its request steady for as long as stall is high. The serial port connects through two byte-wide ready/valid handshakes. The stall drops in the same cycle the handshake completes, so the pipeline can present its next request on the following edge.

Top module: `pin_io_port`

## Requirements
- R1: While reset is asserted and after its release, `ledOut` is 0x0000 and `stall`, `rxReady` and `txValid` are low.
- R2: A write request to pin 0xA6 completes without stall, and `ledOut` holds the write word from the next rising edge.
- R3: `ledOut` is unchanged on any edge without a write request to pin 0xA6, whatever `wrData` carries.
- R4: A read request to pin 0xAA returns the button level in bit 0 with bits 15..1 zero. A change on `btnIn` reaches `rdData` only after two rising edges.
- R5: A read request to pin 0x99 drives `rxReady` high and keeps `stall` high while `rxValid` is low. In the cycle `rxValid` is high, `stall` is low and `rdData` equals `rxData` zero-extended to 16 bits.
- R6: A write request to pin 0xB2 drives `txValid` high with `txData` equal to `wrData[7:0]`, and keeps `stall` high while `txReady` is low. `stall` is low in the cycle `txReady` is high, including the first cycle.
- R7: A request to an unmapped pin, or to a mapped pin in the wrong direction (read of 0xA6 or 0xB2, write to 0xAA or 0x99), completes without stall. A read of such a pin returns 0x0000, and a write to it changes neither `ledOut` nor the serial handshakes.
- R8: `stall`, `rxReady` and `txValid` are only ever high while `reqValid` is high, and at most one of `rxReady` and `txValid` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present; held while stall is high |
| reqWrite | input | 1 | 1 = output instruction, 0 = input instruction |
| pinNum | input | 8 | Pin number from the second register operand |
| wrData | input | 16 | Word to write |
| rdData | output | 16 | Word read, valid in the completing cycle |
| stall | output | 1 | Holds the pipeline while a serial byte is outstanding |
| btnIn | input | 1 | Asynchronous push-button level |
| ledOut | output | 16 | LED register |
| rxValid | input | 1 | Serial receiver has a byte |
| rxData | input | 8 | Received byte |
| rxReady | output | 1 | Block takes the received byte |
| txValid | output | 1 | Byte offered to the serial transmitter |
| txData | output | 8 | Byte to transmit |
| txReady | input | 1 | Serial transmitter accepts the byte |

## Verification
On every cycle, the assertions check several relations. The stall and both handshakes appear only under a request, and never together. A completing receive returns the zero-extended byte without stall. An unmapped access finishes in one cycle with zero data. The LED register holds unless a write to its pin lands, and it loads the right word when one does. Other behaviour shows only in the bench's scenarios: that the stall lasts exactly as many cycles as the serial stub withholds its handshake, the two-edge delay through the button synchronizer, the low-byte truncation on transmit, and the decode of wrong-direction accesses to each mapped pin.

// File: rtl/pio_pkg.sv
package pio_pkg;
  // One strobe per device access, decoded by control and consumed by the datapath
  typedef struct packed {
    logic ledWr;
    logic btnRd;
    logic rxRd;
    logic txWr;
  } ioStrobe_t;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int PIN_W = 8,
  parameter logic [PIN_W-1:0] LED_PIN = 8'hA6,
  parameter logic [PIN_W-1:0] BTN_PIN = 8'hAA,
  parameter logic [PIN_W-1:0] RX_PIN  = 8'h99,
  parameter logic [PIN_W-1:0] TX_PIN  = 8'hB2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [PIN_W-1:0] pinNum,
  input  logic             rxValid,
  input  logic             txReady,
  output ioStrobe_t        strb,
  output logic             stall
);
  logic hitLed, hitBtn, hitRx, hitTx;

  assign hitLed = (pinNum == LED_PIN);
  assign hitBtn = (pinNum == BTN_PIN);
  assign hitRx  = (pinNum == RX_PIN);
  assign hitTx  = (pinNum == TX_PIN);

  // Each device answers only in its own direction; anything else is a no-op
  always_comb begin
    strb.ledWr = reqValid &  reqWrite & hitLed;
    strb.btnRd = reqValid & ~reqWrite & hitBtn;
    strb.rxRd  = reqValid & ~reqWrite & hitRx;
    strb.txWr  = reqValid &  reqWrite & hitTx;
  end

  // Stall falls in the same cycle the serial handshake completes
  assign stall = (strb.rxRd & ~rxValid) | (strb.txWr & ~txReady);

  a_r8_stall_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> reqValid);

  a_r7_mapped_only_stall: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !hitRx && !hitTx) |-> !stall);
endmodule

// File: rtl/pio_dpath.sv
module pio_dpath
  import pio_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ioStrobe_t         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              btnIn,
  input  logic [BYTE_W-1:0] rxData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ledOut,
  output logic [BYTE_W-1:0] txData
);
  localparam int PAD_W = DATA_W - BYTE_W;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   btnSync;

  // LED register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ledOut <= '0;
    else if (strb.ledWr) ledOut <= wrData;
  end

  // Button synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= btnIn;
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  assign btnSync = syncQ[SYNC_STAGES-1];

  // Read mux: zero unless a readable device is addressed
  always_comb begin
    rdData = '0;
    if (strb.rxRd)      rdData = {{PAD_W{1'b0}}, rxData};
    else if (strb.btnRd) rdData = {{(DATA_W-1){1'b0}}, btnSync};
  end

  assign txData = wrData[BYTE_W-1:0];

  a_r3_led_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ledWr |=> $stable(ledOut));

  a_r2_led_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.ledWr |=> ledOut == $past(wrData));
endmodule

// File: rtl/pin_io_port.sv
module pin_io_port
  import pio_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int BYTE_W      = 8,
  parameter int PIN_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [PIN_W-1:0] LED_PIN = 8'hA6,
  parameter logic [PIN_W-1:0] BTN_PIN = 8'hAA,
  parameter logic [PIN_W-1:0] RX_PIN  = 8'h99,
  parameter logic [PIN_W-1:0] TX_PIN  = 8'hB2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [PIN_W-1:0]  pinNum,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              stall,
  input  logic              btnIn,
  output logic [DATA_W-1:0] ledOut,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [BYTE_W-1:0] txData,
  input  logic              txReady
);
  ioStrobe_t strb;

  pio_ctrl #(
    .PIN_W(PIN_W), .LED_PIN(LED_PIN), .BTN_PIN(BTN_PIN),
    .RX_PIN(RX_PIN), .TX_PIN(TX_PIN)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .pinNum(pinNum), .rxValid(rxValid), .txReady(txReady),
    .strb(strb), .stall(stall)
  );

  pio_dpath #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .btnIn(btnIn),
    .rxData(rxData), .rdData(rdData), .ledOut(ledOut), .txData(txData)
  );

  assign rxReady = strb.rxRd;
  assign txValid = strb.txWr;

  a_r5_rx_done: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && rxValid) |-> (!stall && rdData == {{(DATA_W-BYTE_W){1'b0}}, rxData}));

  a_r8_one_serial: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxReady, txValid}) && ((rxReady || txValid) -> reqValid));

  a_r6_tx_done: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |-> !stall);

  a_r7_unmapped: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && pinNum != LED_PIN && pinNum != BTN_PIN && pinNum != RX_PIN
     && pinNum != TX_PIN) |-> (!stall && rdData == '0 && !rxReady && !txValid));
endmodule

// File: tb/pin_io_port_tb_top.sv
`timescale 1ns/1ps
module pin_io_port_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite;
  logic [7:0]  pinNum;
  logic [15:0] wrData, rdData, ledOut;
  logic        stall, btnIn, rxValid, rxReady, txValid, txReady;
  logic [7:0]  rxData, txData;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  pin_io_port dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .pinNum(pinNum), .wrData(wrData), .rdData(rdData), .stall(stall),
    .btnIn(btnIn), .ledOut(ledOut), .rxValid(rxValid), .rxData(rxData),
    .rxReady(rxReady), .txValid(txValid), .txData(txData), .txReady(txReady)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  pin;
    logic [15:0] wdata;
    logic [15:0] expRd;
    logic [15:0] expLed;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hA6, 16'h1234, 16'h0000, 16'h1234},  // R2 LED write
    '{1'b0, 8'hAA, 16'hFFFF, 16'h0001, 16'h1234},  // R4 button read
    '{1'b1, 8'h55, 16'hFFFF, 16'h0000, 16'h1234},  // R7 unmapped write
    '{1'b0, 8'h55, 16'h0000, 16'h0000, 16'h1234},  // R7 unmapped read
    '{1'b0, 8'hA6, 16'h0000, 16'h0000, 16'h1234},  // R7 LED is write-only
    '{1'b1, 8'hAA, 16'hBEEF, 16'h0000, 16'h1234},  // R7 write to button
    '{1'b1, 8'hA6, 16'hA5C3, 16'h0000, 16'hA5C3},  // R2 second LED write
    '{1'b0, 8'hB2, 16'h0000, 16'h0000, 16'hA5C3},  // R7 read of tx pin
    '{1'b1, 8'h99, 16'h7777, 16'h0000, 16'hA5C3}   // R7 write to rx pin
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 1'b0; reqWrite = 1'b0; pinNum = 8'h00; wrData = 16'h0000;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog: actual 0x0001 expected 0x0000");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; btnIn = 1'b0; rxValid = 1'b0; rxData = 8'h00; txReady = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ledOut == 16'h0, "R1 led in reset", ledOut, 16'h0);
    chk(!stall && !rxReady && !txValid, "R1 outputs in reset",
        {13'b0, stall, rxReady, txValid}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(ledOut == 16'h0, "R1 led after reset", ledOut, 16'h0);

    // R4 two-edge synchronizer delay
    btnIn = 1'b1; reqValid = 1'b1; reqWrite = 1'b0; pinNum = 8'hAA;
    @(negedge clk);
    chk(rdData == 16'h0000, "R4 button after one edge", rdData, 16'h0000);
    @(negedge clk);
    chk(rdData == 16'h0001, "R4 button after two edges", rdData, 16'h0001);
    idle();
    @(negedge clk);

    // Table of single-cycle accesses (R2, R4, R7, R8)
    for (int i = 0; i < NV; i++) begin
      reqValid = 1'b1; reqWrite = VEC[i].wr; pinNum = VEC[i].pin;
      wrData = VEC[i].wdata;
      #2;
      chk(rdData == VEC[i].expRd, "R7 vector read data", rdData, VEC[i].expRd);
      chk(!stall && !rxReady && !txValid, "R8 vector no stall or handshake",
          {13'b0, stall, rxReady, txValid}, 16'h0);
      @(negedge clk);
      chk(ledOut == VEC[i].expLed, "R2 vector LED", ledOut, VEC[i].expLed);
    end
    idle();

    // R3 LED holds with no write to its pin
    for (int k = 0; k < 3; k++) begin
      wrData = 16'h0F0F + 16'(k);
      @(negedge clk);
      chk(ledOut == 16'hA5C3, "R3 LED holds", ledOut, 16'hA5C3);
    end
    btnIn = 1'b0;

    // R5 receive with three stalled cycles
    reqValid = 1'b1; reqWrite = 1'b0; pinNum = 8'h99; rxData = 8'hC7;
    for (int k = 0; k < 3; k++) begin
      #2;
      chk(stall && rxReady, "R5 stall while no byte",
          {14'b0, stall, rxReady}, 16'h0003);
      @(negedge clk);
    end
    rxValid = 1'b1;
    #2;
    chk(!stall, "R5 stall drops on handshake", {15'b0, stall}, 16'h0);
    chk(rdData == 16'h00C7, "R5 zero-extended byte", rdData, 16'h00C7);
    @(negedge clk);
    rxValid = 1'b0; idle();
    #2;
    chk(!rxReady, "R8 rxReady drops with request", {15'b0, rxReady}, 16'h0);
    @(negedge clk);

    // R6 transmit with two stalled cycles
    reqValid = 1'b1; reqWrite = 1'b1; pinNum = 8'hB2; wrData = 16'h5A3C;
    for (int k = 0; k < 2; k++) begin
      #2;
      chk(stall && txValid, "R6 stall while not sent",
          {14'b0, stall, txValid}, 16'h0003);
      chk(txData == 8'h3C, "R6 low byte sent", {8'h0, txData}, 16'h003C);
      @(negedge clk);
    end
    txReady = 1'b1;
    #2;
    chk(!stall, "R6 stall drops on handshake", {15'b0, stall}, 16'h0);
    @(negedge clk);
    // R6 back-to-back transmit with ready already high
    wrData = 16'hFF81;
    #2;
    chk(!stall && txValid && txData == 8'h81, "R6 immediate accept",
        {7'b0, stall, txData}, 16'h0081);
    @(negedge clk);
    txReady = 1'b0; idle();
    #2;
    chk(!txValid && !stall, "R8 txValid drops with request",
        {14'b0, stall, txValid}, 16'h0);
    chk(ledOut == 16'hA5C3, "R7 serial traffic leaves LED", ledOut, 16'hA5C3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule